// File: doc/BRIEF.md
# Block Transfer Range and Ready Controller

This block is the control core of a word-by-word block transfer across a parallel DMA link. Software loads a 24-bit range counter with the number of words to move minus one, then issues a GO command. GO drops the master READY bit and sends a one-cycle GO pulse to the attached device. The handshake logic then strobes the block once per transferred word. When the counter passes below zero it wraps to all ones, raises the end-of-range flag and sets READY again. A rising edge on the ATTENTION input, a TERM command or a master clear also return READY to one.

Software commands arrive as a single pulse word. One word may carry several commands, and they take effect in a fixed order: master clear, then the flag clears, then TERM, then GO. The block also drives three function bits to the device. These bits can be written directly, or taken from a read or write preset when a transfer starts. Two further pulse outputs go to the device (INIT and ACF2) without touching internal state. A status word gathers READY, both flags, the live attention level and three device status inputs.

Top module: `xfer_range_ctrl`

## Requirements
- R1: After rst_ni is released, ready_o=1, range_o=0, both flags=0, fcn_o=0, and go_o, init_o and acf2_o are 0. The read preset is 3'b101 and the write preset is 3'b100 (fcn bit 0 is function 1, bit 2 is function 3).
- R2: A cycle with range_load_i=1 (and no master clear) puts range_val_i on range_o at the next edge. A load takes priority over a word strobe in the same cycle.
- R3: A word_stb_i cycle decrements range_o by one only while ready_o=0. While ready_o=1, strobes leave range_o unchanged.
- R4: A strobe taken while range_o=0 gives range_o=24'hFFFFFF, sets the end-of-range flag (status_o bit 1) and sets ready_o, all at the same edge.
- R5: A command word with the GO bit (bit 4), given while attn_i=0, clears ready_o and makes go_o high for exactly one cycle.
- R6: GO given while attn_i=1 is ignored: ready_o keeps its value and go_o stays 0.
- R7: A rising edge on attn_i sets the attention flag (status_o bit 2) and ready_o. status_o bit 3 shows the level of attn_i, registered one cycle.
- R8: Command bit 1 clears the end-of-range flag and bit 2 clears the attention flag. If a hardware set of a flag falls in the same cycle, the set wins.
- R9: Command bit 3 (TERM) sets ready_o. If GO is accepted in the same word, GO acts last and ready_o ends at 0.
- R10: Command bit 0 (master clear) zeroes range_o, both flags and fcn_o, and sets ready_o. The read and write presets are kept. Any GO in the same word still acts after the clear.
- R11: Command bits 5 (INIT) and 6 (ACF2) each give a one-cycle pulse on init_o and acf2_o, with no effect on ready_o, range_o or the flags.
- R12: fcn_we_i with fcn_sel_i=0 writes fcn_o directly, 1 writes the read preset, and 2 writes the write preset. xfer_start_i copies the read preset to fcn_o when xfer_rd_i=1, and the write preset otherwise.
- R13: status_o[6:4] equals sts_i[2:0], and sts_i has no effect on any other output. Bit 0 of status_o is ready_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Pulse command word valid this cycle |
| cmd_i | input | 7 | Pulse command bits (see R5 to R11) |
| range_load_i | input | 1 | Load the range counter |
| range_val_i | input | 24 | Load value (word count minus one) |
| word_stb_i | input | 1 | One transferred word, from the handshake logic |
| attn_i | input | 1 | ATTENTION from the device, synchronous to clk_i |
| fcn_we_i | input | 1 | Function register write enable |
| fcn_sel_i | input | 2 | Function write target: 0 direct, 1 read preset, 2 write preset |
| fcn_val_i | input | 3 | Function write data |
| xfer_start_i | input | 1 | Apply a preset to the function bits |
| xfer_rd_i | input | 1 | Direction for xfer_start_i: 1 read, 0 write |
| sts_i | input | 3 | Device status inputs |
| ready_o | output | 1 | Master READY |
| go_o | output | 1 | One-cycle GO pulse to the device |
| init_o | output | 1 | One-cycle INIT pulse to the device |
| acf2_o | output | 1 | One-cycle ACF2 pulse to the device |
| fcn_o | output | 3 | Function bits to the device |
| range_o | output | 24 | Range counter residual |
| status_o | output | 7 | {sts_i, attn level, attn flag, eor flag, ready} |

## Verification
The assertions assume that attn_i and word_stb_i are already synchronous to clk_i. They also assume that each command word, load and strobe lasts one clock, since every rule is a next-edge relation taken from a single sampled cycle. The bench keeps to this by changing inputs only on the falling edge and holding each stimulus for exactly one cycle. It also raises attention only through clean low-to-high steps, so that every edge it expects a flag for is a real edge.

// File: rtl/xrc_pkg.sv
package xrc_pkg;
  localparam int CMD_W = 7;

  typedef struct packed {
    logic acf2;
    logic init;
    logic go;
    logic term;
    logic attn_clr;
    logic eor_clr;
    logic mclr;
  } cmd_t;

  typedef enum logic [1:0] {
    FSEL_IMM  = 2'd0,
    FSEL_RD   = 2'd1,
    FSEL_WR   = 2'd2,
    FSEL_NONE = 2'd3
  } fsel_e;
endpackage

// File: rtl/xrc_range_cnt.sv
module xrc_range_cnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             stb_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uflow_o
);
  logic dec;

  assign dec     = stb_i & run_i & ~clr_i & ~load_i;
  assign uflow_o = dec & (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (dec)    cnt_o <= cnt_o - 1'b1;
  end

  // R4
  wrap_all_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && run_i && !clr_i && !load_i && cnt_o == '0) |=> (cnt_o == {CNT_W{1'b1}}))
    else $error("range did not wrap");

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i && !load_i) |=> $stable(cnt_o))
    else $error("range moved while idle");

  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (cnt_o == $past(load_val_i)))
    else $error("load lost");
endmodule

// File: rtl/xrc_flags.sv
module xrc_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic attn_i,
  input  logic mclr_i,
  input  logic eor_clr_i,
  input  logic attn_clr_i,
  input  logic term_i,
  input  logic go_i,
  input  logic uflow_i,
  output logic ready_o,
  output logic eor_o,
  output logic attnf_o,
  output logic attn_lvl_o,
  output logic go_o
);
  logic rise, go_ok;
  logic rdy_n, eor_n, attf_n;

  assign rise  = attn_i & ~attn_lvl_o;
  assign go_ok = go_i & ~attn_i;

  // order: master clear, flag clears, hardware sets, TERM, GO
  always_comb begin
    rdy_n  = ready_o;
    eor_n  = eor_o;
    attf_n = attnf_o;
    if (mclr_i) begin
      rdy_n  = 1'b1;
      eor_n  = 1'b0;
      attf_n = 1'b0;
    end
    if (eor_clr_i)  eor_n  = 1'b0;
    if (attn_clr_i) attf_n = 1'b0;
    if (uflow_i) begin
      eor_n = 1'b1;
      rdy_n = 1'b1;
    end
    if (rise) begin
      attf_n = 1'b1;
      rdy_n  = 1'b1;
    end
    if (term_i) rdy_n = 1'b1;
    if (go_ok)  rdy_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o    <= 1'b1;
      eor_o      <= 1'b0;
      attnf_o    <= 1'b0;
      attn_lvl_o <= 1'b0;
      go_o       <= 1'b0;
    end else begin
      ready_o    <= rdy_n;
      eor_o      <= eor_n;
      attnf_o    <= attf_n;
      attn_lvl_o <= attn_i;
      go_o       <= go_ok;
    end
  end

  // R5
  go_clears_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !attn_i) |=> (!ready_o && go_o))
    else $error("GO not taken");

  // R6
  go_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && attn_i && ready_o) |=> (ready_o && !go_o))
    else $error("GO taken under attention");

  // R7
  attn_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attn_i && !attn_lvl_o) |=> (attnf_o && ready_o))
    else $error("attention edge missed");

  // R9
  term_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !go_i) |=> ready_o)
    else $error("TERM did not set ready");

  // R5
  go_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> (!go_o || $past(go_i)))
    else $error("GO pulse stretched");
endmodule

// File: rtl/xrc_fcn.sv
module xrc_fcn
  import xrc_pkg::*;
#(
  parameter int         FCN_W  = 3,
  parameter logic [2:0] RD_DEF = 3'b101,
  parameter logic [2:0] WR_DEF = 3'b100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  fsel_e            sel_i,
  input  logic [FCN_W-1:0] val_i,
  input  logic             start_i,
  input  logic             rd_i,
  output logic [FCN_W-1:0] fcn_o
);
  logic [FCN_W-1:0] rd_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= FCN_W'(RD_DEF);
      wr_q <= FCN_W'(WR_DEF);
    end else if (we_i) begin
      if (sel_i == FSEL_RD) rd_q <= val_i;
      if (sel_i == FSEL_WR) wr_q <= val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         fcn_o <= '0;
    else if (clr_i)                      fcn_o <= '0;
    else if (start_i)                    fcn_o <= rd_i ? rd_q : wr_q;
    else if (we_i && sel_i == FSEL_IMM)  fcn_o <= val_i;
  end

  // R10
  mclr_fcn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (fcn_o == '0))
    else $error("function bits survived clear");

  // R12
  fcn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !start_i && !we_i) |=> $stable(fcn_o))
    else $error("function bits moved");
endmodule

// File: rtl/xfer_range_ctrl.sv
module xfer_range_ctrl
  import xrc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int FCN_W = 3,
  parameter int STS_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic               range_load_i,
  input  logic [CNT_W-1:0]   range_val_i,
  input  logic               word_stb_i,
  input  logic               attn_i,
  input  logic               fcn_we_i,
  input  logic [1:0]         fcn_sel_i,
  input  logic [FCN_W-1:0]   fcn_val_i,
  input  logic               xfer_start_i,
  input  logic               xfer_rd_i,
  input  logic [STS_W-1:0]   sts_i,
  output logic               ready_o,
  output logic               go_o,
  output logic               init_o,
  output logic               acf2_o,
  output logic [FCN_W-1:0]   fcn_o,
  output logic [CNT_W-1:0]   range_o,
  output logic [STS_W+3:0]   status_o
);
  cmd_t cmd;
  logic uflow, eor_f, attn_f, attn_lvl;

  assign cmd = cmd_valid_i ? cmd_t'(cmd_i) : '0;

  xrc_range_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cmd.mclr),
    .load_i     (range_load_i),
    .load_val_i (range_val_i),
    .stb_i      (word_stb_i),
    .run_i      (~ready_o),
    .cnt_o      (range_o),
    .uflow_o    (uflow)
  );

  xrc_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .attn_i     (attn_i),
    .mclr_i     (cmd.mclr),
    .eor_clr_i  (cmd.eor_clr),
    .attn_clr_i (cmd.attn_clr),
    .term_i     (cmd.term),
    .go_i       (cmd.go),
    .uflow_i    (uflow),
    .ready_o    (ready_o),
    .eor_o      (eor_f),
    .attnf_o    (attn_f),
    .attn_lvl_o (attn_lvl),
    .go_o       (go_o)
  );

  xrc_fcn #(.FCN_W(FCN_W)) u_fcn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cmd.mclr),
    .we_i    (fcn_we_i),
    .sel_i   (fsel_e'(fcn_sel_i)),
    .val_i   (fcn_val_i),
    .start_i (xfer_start_i),
    .rd_i    (xfer_rd_i),
    .fcn_o   (fcn_o)
  );

  // device-only pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_o <= 1'b0;
      acf2_o <= 1'b0;
    end else begin
      init_o <= cmd.init;
      acf2_o <= cmd.acf2;
    end
  end

  assign status_o = {sts_i, attn_lvl, attn_f, eor_f, ready_o};

  // R10
  mclr_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.mclr && !cmd.go) |=> (ready_o && range_o == '0 && !eor_f && !attn_f))
    else $error("master clear incomplete");

  // R11
  init_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |=> (!init_o || $past(cmd.init)))
    else $error("INIT stretched");

  // R4
  eor_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eor_f) |-> ready_o)
    else $error("end of range without ready");
endmodule

// File: tb/sim_xfer_range_ctrl.sv
module sim_xfer_range_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [6:0]  cmd_i = '0;
  logic        range_load_i = 1'b0;
  logic [23:0] range_val_i = '0;
  logic        word_stb_i = 1'b0;
  logic        attn_i = 1'b0;
  logic        fcn_we_i = 1'b0;
  logic [1:0]  fcn_sel_i = '0;
  logic [2:0]  fcn_val_i = '0;
  logic        xfer_start_i = 1'b0;
  logic        xfer_rd_i = 1'b0;
  logic [2:0]  sts_i = '0;
  logic        ready_o, go_o, init_o, acf2_o;
  logic [2:0]  fcn_o;
  logic [23:0] range_o;
  logic [6:0]  status_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  xfer_range_ctrl u0 (.*, .clk_i(clk));

  localparam int NV = 5;
  localparam logic [23:0] V_LOAD [NV] = '{24'd4, 24'd4, 24'd0, 24'hFFFFFF, 24'd2};
  localparam int          V_NSTB [NV] = '{3, 5, 1, 2, 6};
  localparam logic [23:0] V_EXP  [NV] = '{24'd1, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFD, 24'hFFFFFF};
  localparam logic        V_RDY  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [6:0] c);
    cmd_valid_i = 1'b1; cmd_i = c;
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_i = '0;
  endtask

  task automatic load(input logic [23:0] v);
    range_load_i = 1'b1; range_val_i = v;
    @(negedge clk);
    range_load_i = 1'b0;
  endtask

  task automatic fcn_wr(input logic [1:0] s, input logic [2:0] v);
    fcn_we_i = 1'b1; fcn_sel_i = s; fcn_val_i = v;
    @(negedge clk);
    fcn_we_i = 1'b0;
  endtask

  task automatic start(input logic rd);
    xfer_start_i = 1'b1; xfer_rd_i = rd;
    @(negedge clk);
    xfer_start_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", ready_o, 1);
    chk("R1 range", range_o, 0);
    chk("R1 status", status_o, 7'h01);
    chk("R1 fcn", fcn_o, 0);
    chk("R1 pulses", {go_o, init_o, acf2_o}, 0);
    // R12 default presets
    start(1'b0);
    chk("R12 write preset default", fcn_o, 3'b100);
    start(1'b1);
    chk("R12 read preset default", fcn_o, 3'b101);
    fcn_wr(2'd0, 3'b010);
    chk("R12 direct write", fcn_o, 3'b010);

    // table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      cmd(7'h02);
      load(V_LOAD[i]);
      chk("R2 load", range_o, V_LOAD[i]);
      cmd(7'h10);
      chk("R5 go pulse", go_o, 1);
      chk("R5 ready low", ready_o, 0);
      for (int k = 0; k < V_NSTB[i]; k++) begin
        word_stb_i = 1'b1;
        @(negedge clk);
      end
      word_stb_i = 1'b0;
      chk("R5 go one cycle", go_o, 0);
      chk("R3 R4 range", range_o, V_EXP[i]);
      chk("R4 ready", ready_o, V_RDY[i]);
      chk("R4 eor flag", status_o[1], V_RDY[i]);
    end

    // R2 load beats strobe in the same cycle
    range_load_i = 1'b1; range_val_i = 24'd9; word_stb_i = 1'b1;
    @(negedge clk);
    range_load_i = 1'b0; word_stb_i = 1'b0;
    chk("R2 load priority", range_o, 24'd9);

    // R8 eor clear
    cmd(7'h02);
    chk("R8 eor cleared", status_o[1], 0);

    // R6 R7: attention while idle, GO ignored
    attn_i = 1'b1;
    @(negedge clk);
    chk("R7 attn flag", status_o[2], 1);
    chk("R7 attn level", status_o[3], 1);
    chk("R7 ready", ready_o, 1);
    cmd(7'h10);
    chk("R6 no go pulse", go_o, 0);
    chk("R6 ready kept", ready_o, 1);

    // R8 attention clear
    attn_i = 1'b0;
    cmd(7'h04);
    chk("R8 attn cleared", status_o[2], 0);
    chk("R7 level low", status_o[3], 0);

    // R7 attention ends a running block
    cmd(7'h10);
    chk("R7 running", ready_o, 0);
    attn_i = 1'b1;
    @(negedge clk);
    chk("R7 attn sets ready", ready_o, 1);
    chk("R7 flag set", status_o[2], 1);
    attn_i = 1'b0;
    cmd(7'h04);

    // R8 set wins over clear
    attn_i = 1'b1; cmd_valid_i = 1'b1; cmd_i = 7'h04;
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_i = '0; attn_i = 1'b0;
    chk("R8 set beats clear", status_o[2], 1);
    cmd(7'h04);

    // R9 TERM
    cmd(7'h10);
    chk("R9 ready low", ready_o, 0);
    cmd(7'h08);
    chk("R9 term sets ready", ready_o, 1);
    cmd(7'h18);
    chk("R9 go after term", ready_o, 0);
    chk("R9 go pulse", go_o, 1);
    cmd(7'h08);

    // R10 master clear
    load(24'd5);
    fcn_wr(2'd1, 3'b110);
    fcn_wr(2'd0, 3'b011);
    cmd(7'h10);
    attn_i = 1'b1;
    @(negedge clk);
    attn_i = 1'b0;
    cmd(7'h01);
    chk("R10 range", range_o, 0);
    chk("R10 fcn", fcn_o, 0);
    chk("R10 ready", ready_o, 1);
    chk("R10 flags", status_o[2:1], 0);
    start(1'b1);
    chk("R10 R12 preset kept", fcn_o, 3'b110);
    cmd(7'h11);
    chk("R10 go after clear", ready_o, 0);
    cmd(7'h08);

    // R11 INIT / ACF2
    load(24'd7);
    cmd(7'h60);
    chk("R11 pulses", {init_o, acf2_o}, 2'b11);
    chk("R11 ready", ready_o, 1);
    chk("R11 range", range_o, 24'd7);
    @(negedge clk);
    chk("R11 one cycle", {init_o, acf2_o}, 2'b00);

    // R13 status inputs
    sts_i = 3'b101;
    @(negedge clk);
    chk("R13 status", status_o, {3'b101, 4'b0001});
    chk("R13 range", range_o, 24'd7);
    sts_i = 3'b010;
    @(negedge clk);
    chk("R13 status b", status_o[6:4], 3'b010);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule